// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

A small 32-bit in-order processor with five stages (fetch, decode/register read, execute, memory, writeback). It runs eight instructions: word load and store, register add, subtract and AND, OR and add with a 16-bit immediate, and branch-if-equal. The main decoder builds one control word while an instruction sits in decode. The word is then split by stage: the execute part, the memory part and the writeback part each ride in the pipeline registers beside the operands, the ALU result and the loaded data. Each part is used in the stage it belongs to.

The branch is resolved in decode. The instruction after a branch (its delay slot) always runs, and fetch moves to the target on the next cycle. Results are not forwarded and there is no interlock. An instruction that reads a register written by one of the two instructions before it gets the old value. A value written back is visible to decode in the same cycle, so the third instruction after a writer sees the new value. Instruction and data memories are internal word arrays. A load port fills them while reset is held. Writeback and store activity appear on trace outputs.

Top module: `pipe5_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and neither wb_we_o nor st_we_o is asserted. Fetch begins at byte address 0 after release.
- R2: Count rising edges after reset release as cycle 1, 2 and so on. On a straight-line path, the instruction at word k shows its writeback on wb_* after edge k+4 and its store on st_* after edge k+3. No cycle is lost between instructions.
- R3: R-type words (opcode 0x00) with funct 0x20, 0x22 and 0x24 write rs+rt, rs-rt and rs&rt to rd (bits 15:11). Any other opcode or funct writes nothing. The all-zero word is therefore a no-op.
- R4: ori (opcode 0x0d) writes rs | zero-extended imm16 to rt (bits 20:16). addi (opcode 0x08) writes rs + sign-extended imm16 to rt.
- R5: lw (0x23) loads the data word at byte address rs+sext(imm16) into rt. sw (0x2b) writes rt to that word and shows it on st_addr_o/st_data_o. A load issued after a store reads the stored value.
- R6: The instruction directly after a beq (opcode 0x04) always executes, whether or not the branch is taken.
- R7: A taken beq (rs == rt) fetches next from (beq address + 4) + (sext(imm16) << 2), right after the delay slot. A beq that is not taken continues in sequence.
- R8: There is no interlock. The first and second instructions after a writer (load or ALU) read the register's previous value, and no stall is inserted.
- R9: The third instruction after a writer reads the new value, because the register file passes a same-cycle write through to decode.
- R10: Register 0 reads as zero. A write to it changes nothing and raises no wb_we_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_imem_we_i | input | 1 | Write ld_data_i into instruction memory word ld_addr_i |
| ld_dmem_we_i | input | 1 | Write ld_data_i into data memory word ld_addr_i |
| ld_addr_i | input | 6 | Word index for preload |
| ld_data_i | input | 32 | Preload data |
| pc_o | output | 32 | Current fetch address |
| wb_we_o | output | 1 | Register write this cycle |
| wb_addr_o | output | 5 | Destination register |
| wb_data_o | output | 32 | Value written |
| st_we_o | output | 1 | Store in memory stage this cycle |
| st_addr_o | output | 32 | Store byte address |
| st_data_o | output | 32 | Store data |

## Verification
The assertions assume two things. First, the memories are loaded only while reset is held. Second, programs contain only the eight instructions or all-zero no-ops, so every branch, store and register write traces back to the control word made in decode. The stimulus keeps to this. Every program is loaded under reset, runs from address 0, and has unused instruction words left at zero. Sweeps over operand pairs, a branch program and a load-delay program put hazards only where a requirement calls for their stale or fresh result.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2b;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ORI   = 6'h0d;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;
  localparam logic [5:0] FN_AND   = 6'h24;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    ext_signed;
    logic    alu_imm;
    alu_op_e alu_op;
    logic    dst_rd;
  } ex_ctrl_t;

  typedef struct packed {
    logic mem_wr;
  } me_ctrl_t;

  typedef struct packed {
    logic mem_to_reg;
    logic reg_wr;
  } wb_ctrl_t;

  typedef struct packed {
    ex_ctrl_t ex;
    me_ctrl_t me;
    wb_ctrl_t wb;
    logic     branch;
  } ctrl_t;
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    case (op_i)
      OP_RTYPE: begin
        ctrl_o.ex.dst_rd = 1'b1;
        case (funct_i)
          FN_ADD: begin ctrl_o.ex.alu_op = ALU_ADD; ctrl_o.wb.reg_wr = 1'b1; end
          FN_SUB: begin ctrl_o.ex.alu_op = ALU_SUB; ctrl_o.wb.reg_wr = 1'b1; end
          FN_AND: begin ctrl_o.ex.alu_op = ALU_AND; ctrl_o.wb.reg_wr = 1'b1; end
          default: ;
        endcase
      end
      OP_LW: begin
        ctrl_o.ex.ext_signed = 1'b1;
        ctrl_o.ex.alu_imm    = 1'b1;
        ctrl_o.wb.mem_to_reg = 1'b1;
        ctrl_o.wb.reg_wr     = 1'b1;
      end
      OP_SW: begin
        ctrl_o.ex.ext_signed = 1'b1;
        ctrl_o.ex.alu_imm    = 1'b1;
        ctrl_o.me.mem_wr     = 1'b1;
      end
      OP_ADDI: begin
        ctrl_o.ex.ext_signed = 1'b1;
        ctrl_o.ex.alu_imm    = 1'b1;
        ctrl_o.wb.reg_wr     = 1'b1;
      end
      OP_ORI: begin
        ctrl_o.ex.alu_imm = 1'b1;
        ctrl_o.ex.alu_op  = ALU_OR;
        ctrl_o.wb.reg_wr  = 1'b1;
      end
      OP_BEQ: ctrl_o.branch = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    ra_a_i,
  input  logic [AW-1:0]    ra_b_i,
  output logic [WIDTH-1:0] rd_a_o,
  output logic [WIDTH-1:0] rd_b_o,
  input  logic             we_i,
  input  logic [AW-1:0]    wa_i,
  input  logic [WIDTH-1:0] wd_i
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  // same-cycle write is visible to decode
  always_comb begin
    if (ra_a_i == '0)                    rd_a_o = '0;
    else if (we_i && wa_i == ra_a_i)     rd_a_o = wd_i;
    else                                 rd_a_o = mem_q[ra_a_i];
    if (ra_b_i == '0)                    rd_b_o = '0;
    else if (we_i && wa_i == ra_b_i)     rd_b_o = wd_i;
    else                                 rd_b_o = mem_q[ra_b_i];
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int WIDTH = XLEN
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_op_e          op_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREGS      = 32,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW,
  localparam int RAW = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_imem_we_i,
  input  logic            ld_dmem_we_i,
  input  logic [LAW-1:0]  ld_addr_i,
  input  logic [XLEN-1:0] ld_data_i,
  output logic [XLEN-1:0] pc_o,
  output logic            wb_we_o,
  output logic [RAW-1:0]  wb_addr_o,
  output logic [XLEN-1:0] wb_data_o,
  output logic            st_we_o,
  output logic [XLEN-1:0] st_addr_o,
  output logic [XLEN-1:0] st_data_o
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // fetch
  logic [XLEN-1:0] pc_q, pc_d, ifde_ir, ifde_pc4;
  // decode
  ctrl_t           de_ctrl;
  logic [RAW-1:0]  de_rs, de_rt, de_rd;
  logic [15:0]     de_imm;
  logic [XLEN-1:0] de_a, de_b, br_target;
  logic            br_taken;
  // execute
  ex_ctrl_t        deex_ex;
  me_ctrl_t        deex_me;
  wb_ctrl_t        deex_wb;
  logic [XLEN-1:0] deex_a, deex_b;
  logic [15:0]     deex_imm;
  logic [RAW-1:0]  deex_rt, deex_rd, ex_dst;
  logic [XLEN-1:0] ex_ext, ex_opb, ex_y;
  // memory
  me_ctrl_t        exme_me;
  wb_ctrl_t        exme_wb;
  logic [XLEN-1:0] exme_alu, exme_b, me_rdata;
  logic [RAW-1:0]  exme_dst;
  // writeback
  wb_ctrl_t        mewb_wb;
  logic [XLEN-1:0] mewb_alu, mewb_mem, wb_data;
  logic [RAW-1:0]  mewb_dst;
  logic            rf_we;

  always_ff @(posedge clk_i) begin
    if (ld_imem_we_i) imem[ld_addr_i[IAW-1:0]] <= ld_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (ld_dmem_we_i)        dmem[ld_addr_i[DAW-1:0]] <= ld_data_i;
    else if (exme_me.mem_wr) dmem[exme_alu[DAW+1:2]] <= exme_b;
  end

  // ---------------- fetch
  assign pc_d = br_taken ? br_target : pc_q + XLEN'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      ifde_ir  <= '0;
      ifde_pc4 <= '0;
    end else begin
      pc_q     <= pc_d;
      ifde_ir  <= imem[pc_q[IAW+1:2]];
      ifde_pc4 <= pc_q + XLEN'(4);
    end
  end

  // ---------------- decode
  assign de_rs  = ifde_ir[25:21];
  assign de_rt  = ifde_ir[20:16];
  assign de_rd  = ifde_ir[15:11];
  assign de_imm = ifde_ir[15:0];

  pipe5_decode u_dec (
    .op_i   (ifde_ir[31:26]),
    .funct_i(ifde_ir[5:0]),
    .ctrl_o (de_ctrl)
  );

  pipe5_regfile #(.DEPTH(NREGS), .WIDTH(XLEN)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_a_i(de_rs),
    .ra_b_i(de_rt),
    .rd_a_o(de_a),
    .rd_b_o(de_b),
    .we_i  (rf_we),
    .wa_i  (mewb_dst),
    .wd_i  (wb_data)
  );

  // branch resolved here: exactly one delay slot
  assign br_taken  = de_ctrl.branch && (de_a == de_b);
  assign br_target = ifde_pc4 + {{(XLEN-18){de_imm[15]}}, de_imm, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deex_ex  <= '0;
      deex_me  <= '0;
      deex_wb  <= '0;
      deex_a   <= '0;
      deex_b   <= '0;
      deex_imm <= '0;
      deex_rt  <= '0;
      deex_rd  <= '0;
    end else begin
      deex_ex  <= de_ctrl.ex;
      deex_me  <= de_ctrl.me;
      deex_wb  <= de_ctrl.wb;
      deex_a   <= de_a;
      deex_b   <= de_b;
      deex_imm <= de_imm;
      deex_rt  <= de_rt;
      deex_rd  <= de_rd;
    end
  end

  // ---------------- execute
  assign ex_ext = deex_ex.ext_signed ? {{(XLEN-16){deex_imm[15]}}, deex_imm}
                                     : {{(XLEN-16){1'b0}}, deex_imm};
  assign ex_opb = deex_ex.alu_imm ? ex_ext : deex_b;
  assign ex_dst = deex_ex.dst_rd ? deex_rd : deex_rt;

  pipe5_alu #(.WIDTH(XLEN)) u_alu (
    .a_i (deex_a),
    .b_i (ex_opb),
    .op_i(deex_ex.alu_op),
    .y_o (ex_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exme_me  <= '0;
      exme_wb  <= '0;
      exme_alu <= '0;
      exme_b   <= '0;
      exme_dst <= '0;
    end else begin
      exme_me  <= deex_me;
      exme_wb  <= deex_wb;
      exme_alu <= ex_y;
      exme_b   <= deex_b;
      exme_dst <= ex_dst;
    end
  end

  // ---------------- memory
  assign me_rdata = dmem[exme_alu[DAW+1:2]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mewb_wb  <= '0;
      mewb_alu <= '0;
      mewb_mem <= '0;
      mewb_dst <= '0;
    end else begin
      mewb_wb  <= exme_wb;
      mewb_alu <= exme_alu;
      mewb_mem <= me_rdata;
      mewb_dst <= exme_dst;
    end
  end

  // ---------------- writeback
  assign wb_data = mewb_wb.mem_to_reg ? mewb_mem : mewb_alu;
  assign rf_we   = mewb_wb.reg_wr && (mewb_dst != '0);

  assign pc_o      = pc_q;
  assign wb_we_o   = rf_we;
  assign wb_addr_o = mewb_dst;
  assign wb_data_o = wb_data;
  assign st_we_o   = exme_me.mem_wr;
  assign st_addr_o = exme_alu;
  assign st_data_o = exme_b;

  // ---------------- assertions
  // R2: writeback control was produced in decode three cycles earlier
  p_wb_ctrl_age_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mewb_wb.reg_wr |-> $past(de_ctrl.wb.reg_wr, 3));

  // R5: memory-write control was produced in decode two cycles earlier
  p_st_ctrl_age_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exme_me.mem_wr |-> $past(de_ctrl.me.mem_wr, 2));

  // R6: after a taken branch the next decoded word is the sequential delay slot
  p_delay_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(br_taken) |-> ifde_pc4 == $past(ifde_pc4) + XLEN'(4));

  // R7: the word decoded after the delay slot comes from the branch target
  p_redirect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(br_taken, 2) |-> ifde_pc4 == $past(br_target, 2) + XLEN'(4));
endmodule

// File: tb/pipe5_core_test.sv
module pipe5_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic        wb_we_o, st_we_o;
  logic [4:0]  wb_addr_o;

  pipe5_core uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_imem_we_i(ld_imem_we), .ld_dmem_we_i(ld_dmem_we),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .pc_o(pc_o), .wb_we_o(wb_we_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
    .st_we_o(st_we_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] prog [NW];
  logic [31:0] dat  [NW];

  int cyc = 0;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  int          wb_n = 0, st_n = 0;
  logic [4:0]  wb_a [32];
  logic [31:0] wb_d [32];
  int          wb_c [32];
  logic [31:0] st_a [32], st_d [32];
  int          st_c [32];

  always @(negedge clk) begin
    if (rst_n) begin
      if (wb_we_o && wb_n < 32) begin
        wb_a[wb_n] = wb_addr_o; wb_d[wb_n] = wb_data_o; wb_c[wb_n] = cyc; wb_n++;
      end
      if (st_we_o && st_n < 32) begin
        st_a[st_n] = st_addr_o; st_d[st_n] = st_data_o; st_c[st_n] = cyc; st_n++;
      end
    end
  end

  function automatic logic [31:0] rtype(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_wb(string req, int i, int a, logic [31:0] d, int c);
    if (i >= wb_n) begin
      n_chk++; n_fail++;
      $display("FAIL %s missing writeback #%0d actual=%0d expected>%0d", req, i, wb_n, i);
    end else begin
      chk(req, 32'(wb_a[i]), 32'(a));
      chk(req, wb_d[i], d);
      chk(req, 32'(wb_c[i]), 32'(c));
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < NW; i++) begin prog[i] = '0; dat[i] = '0; end
  endtask

  task automatic load_and_run(int ncyc, bit check_reset);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      ld_imem_we = 1'b1; ld_dmem_we = 1'b1; ld_addr = 6'(i);
      ld_data = prog[i];
      @(negedge clk);
      ld_imem_we = 1'b0;
      ld_data = dat[i];
    end
    @(negedge clk);
    ld_imem_we = 1'b0; ld_dmem_we = 1'b0;
    if (check_reset) begin
      chk("R1 pc in reset", pc_o, 32'h0);
      chk("R1 wb_we in reset", 32'(wb_we_o), 32'h0);
      chk("R1 st_we in reset", 32'(st_we_o), 32'h0);
    end
    wb_n = 0; st_n = 0;
    rst_n = 1'b1;
    repeat (ncyc) @(negedge clk);
  endtask

  localparam int NV = 8;
  logic [31:0] vals [NV] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                             32'h8000_0000, 32'h0000_8001, 32'h1234_5678, 32'hFFFF_7FFE};

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // ALU / immediate / load-store sweep (R1..R5, R2 timing)
    for (int xi = 0; xi < NV; xi++) begin
      for (int yi = 0; yi < NV; yi++) begin
        logic [31:0] x, y;
        logic [15:0] imm;
        x = vals[xi]; y = vals[yi]; imm = y[15:0];
        clear_prog();
        dat[0] = x; dat[1] = y;
        prog[0] = itype(6'h23, 0, 1, 16'd0);
        prog[1] = itype(6'h23, 0, 2, 16'd4);
        prog[4] = rtype(1, 2, 3, 6'h20);
        prog[5] = rtype(1, 2, 4, 6'h22);
        prog[6] = rtype(1, 2, 5, 6'h24);
        prog[7] = itype(6'h0d, 1, 6, imm);
        prog[8] = itype(6'h08, 1, 7, imm);
        prog[9] = itype(6'h2b, 0, 4, 16'd8);
        load_and_run(16, (xi == 0 && yi == 0));
        chk("R5 lw count", 32'(wb_n), 32'd7);
        chk_wb("R5 lw r1 / R2 latency", 0, 1, x, 4);
        chk_wb("R5 lw r2", 1, 2, y, 5);
        chk_wb("R3 add", 2, 3, x + y, 8);
        chk_wb("R3 sub", 3, 4, x - y, 9);
        chk_wb("R3 and", 4, 5, x & y, 10);
        chk_wb("R4 ori zero-extend", 5, 6, x | {16'h0, imm}, 11);
        chk_wb("R4 addi sign-extend", 6, 7, x + {{16{imm[15]}}, imm}, 12);
        chk("R5 store count", 32'(st_n), 32'd1);
        if (st_n > 0) begin
          chk("R5 store addr", st_a[0], 32'd8);
          chk("R5 store data", st_d[0], x - y);
          chk("R2 store cycle", 32'(st_c[0]), 32'd12);
        end
      end
    end

    // branch program (R6, R7)
    clear_prog();
    prog[0]  = itype(6'h08, 0, 1, 16'd7);
    prog[1]  = itype(6'h08, 0, 2, 16'd7);
    prog[4]  = itype(6'h04, 1, 2, 16'd3);   // taken -> word 8
    prog[5]  = itype(6'h08, 0, 3, 16'd1);   // delay slot
    prog[6]  = itype(6'h08, 0, 4, 16'd2);
    prog[7]  = itype(6'h08, 0, 5, 16'd3);
    prog[8]  = itype(6'h08, 0, 6, 16'd4);
    prog[9]  = itype(6'h04, 1, 0, 16'd5);   // not taken
    prog[10] = itype(6'h08, 0, 7, 16'd5);
    prog[11] = itype(6'h08, 0, 8, 16'd6);
    prog[12] = itype(6'h08, 0, 9, 16'd9);
    load_and_run(20, 1'b0);
    chk("R7 branch event count", 32'(wb_n), 32'd7);
    chk_wb("R7 pre-branch r1", 0, 1, 32'd7, 4);
    chk_wb("R7 pre-branch r2", 1, 2, 32'd7, 5);
    chk_wb("R6 taken delay slot runs", 2, 3, 32'd1, 9);
    chk_wb("R7 taken target reached", 3, 6, 32'd4, 10);
    chk_wb("R6 untaken delay slot runs", 4, 7, 32'd5, 12);
    chk_wb("R7 untaken fall-through", 5, 8, 32'd6, 13);
    chk_wb("R7 untaken next", 6, 9, 32'd9, 14);

    // load delay, bypass and r0 program (R8, R9, R10, R5)
    clear_prog();
    dat[0] = 32'h11; dat[1] = 32'h22;
    prog[0]  = itype(6'h08, 0, 9, 16'h55);
    prog[3]  = itype(6'h23, 0, 9, 16'd0);
    prog[4]  = rtype(9, 0, 10, 6'h20);
    prog[5]  = rtype(9, 0, 11, 6'h20);
    prog[6]  = rtype(9, 0, 12, 6'h20);
    prog[7]  = itype(6'h2b, 0, 9, 16'd4);
    prog[8]  = itype(6'h23, 0, 13, 16'd4);
    prog[9]  = itype(6'h08, 0, 0, 16'd5);
    prog[12] = rtype(0, 0, 14, 6'h20);
    load_and_run(22, 1'b0);
    chk("R10 no r0 writeback event", 32'(wb_n), 32'd7);
    chk_wb("R8 setup r9", 0, 9, 32'h55, 4);
    chk_wb("R8 lw r9", 1, 9, 32'h11, 7);
    chk_wb("R8 first reader stale no stall", 2, 10, 32'h55, 8);
    chk_wb("R8 second reader stale", 3, 11, 32'h55, 9);
    chk_wb("R9 third reader sees new", 4, 12, 32'h11, 10);
    chk_wb("R5 load after store", 5, 13, 32'h11, 12);
    chk_wb("R10 r0 reads zero", 6, 14, 32'h0, 16);
    chk("R5 store count", 32'(st_n), 32'd1);
    if (st_n > 0) begin
      chk("R5 store addr", st_a[0], 32'd4);
      chk("R5 store data", st_d[0], 32'h11);
      chk("R2 store cycle", 32'(st_c[0]), 32'd10);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule